// File: doc/BRIEF.md
# Register Producer Rename Table

This block holds, for every architectural floating-point register, the identity of the reservation station that will produce its next value, or a blank mark when no issued instruction is still to write it. When an instruction issues, the block answers two source lookups in the same cycle. For each source it says either that the operand can be read from the register file, or which station tag the instruction must wait for. In the same cycle it records the issuing station's tag against the destination register, which renames that register.

On every result broadcast the block compares the broadcast tag with each register's recorded producer. A register whose producer matches goes back to blank, and its register-file write enable is raised. A register that has since been renamed to a younger producer keeps its entry, and its register file is not written. An older result therefore never overwrites a newer one, and write-after-write ordering needs no stall. Tags are station numbers, so there may be more stations than registers.

A lookup made in the same cycle as the broadcast it waits for is reported ready, with the broadcast value passed straight through. Reservation stations, functional units and the register file storage all sit outside the block.

Top module: `regstat_rename`

## Requirements
- R1: After reset every register entry is blank: both lookups report ready with no forwarding, and a broadcast of any tag raises no write enable.
- R2: An issue (issueValid high) to register d with tag t makes later lookups of d report not ready with srcXTag equal to t, until t is broadcast.
- R3: A lookup of a blank register reports ready with srcXFwd low.
- R4: A broadcast (cdbValid high) whose tag equals the recorded producer of register r sets bit r of rfWrEn and drives rfWrData with cdbData in that cycle. Register r is blank from the next cycle.
- R5: A broadcast whose tag differs from a register's recorded producer leaves that register's entry unchanged and its rfWrEn bit low. This holds also when the tag was an older producer of that register.
- R6: An issue and a matching broadcast to the same register in the same cycle leave the new issuer's tag recorded.
- R7: A lookup in the same cycle as a broadcast matching that register's producer reports ready, with srcXFwd high and srcXFwdData equal to cdbData. srcXFwdData is zero whenever srcXFwd is low.
- R8: A broadcast clears only the register whose producer matches; other pending registers keep their tags.
- R9: A lookup in the same cycle as an issue to the same register returns that register's state from before the issue.
- R10: With issueValid low, issue inputs change no entry. With cdbValid low, no entry is cleared and rfWrEn stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction issues this cycle |
| issueDst | input | REG_W | Destination register of the issuing instruction |
| issueTag | input | TAG_W | Station tag of the issuing instruction |
| srcAIdx | input | REG_W | First source register looked up |
| srcBIdx | input | REG_W | Second source register looked up |
| cdbValid | input | 1 | A result is broadcast this cycle |
| cdbTag | input | TAG_W | Station tag of the broadcast result |
| cdbData | input | DATA_W | Broadcast result value |
| srcAReady | output | 1 | First source available (register file or forward) |
| srcATag | output | TAG_W | Producer tag of first source when not ready |
| srcAFwd | output | 1 | First source taken from this cycle's broadcast |
| srcAFwdData | output | DATA_W | Forwarded value for the first source |
| srcBReady | output | 1 | Second source available |
| srcBTag | output | TAG_W | Producer tag of second source when not ready |
| srcBFwd | output | 1 | Second source taken from this cycle's broadcast |
| srcBFwdData | output | DATA_W | Forwarded value for the second source |
| rfWrEn | output | NUM_REGS | Per-register register-file write enable |
| rfWrData | output | DATA_W | Register-file write value |

## Verification
The bench renames one register twice and then broadcasts the older tag. A design without the latest-producer check would raise the write enable and clear the entry, so the younger instruction's value would later be lost. It issues to a register in the same cycle as the broadcast of that register's old producer. Giving the clear priority would leave the register blank while a producer is still pending. It also looks up registers in the cycle of their matching broadcast and in the cycle of their own issue. A missing bypass shows up as a stale not-ready answer, and a lookup that sees the new tag too early shows up as a wrong tag. Finally, all registers are filled and broadcast in reverse order to catch a clear that touches neighbouring entries.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  parameter int unsigned NUM_REGS = 8;
  parameter int unsigned NUM_TAGS = 16;
  parameter int unsigned DATA_W   = 32;
  localparam int unsigned REG_W = $clog2(NUM_REGS);
  localparam int unsigned TAG_W = $clog2(NUM_TAGS);

  typedef logic [REG_W-1:0] regIdx_t;
  typedef logic [TAG_W-1:0] tag_t;

  // Per-register strobes from control to datapath
  typedef struct packed {
    logic [NUM_REGS-1:0] alloc;
    logic [NUM_REGS-1:0] retire;
  } strobes_t;
endpackage

// File: rtl/rrs_ctrl.sv
module rrs_ctrl
  import rrs_pkg::*;
(
  input  logic                issueValid,
  input  regIdx_t             issueDst,
  input  logic                cdbValid,
  input  tag_t                cdbTag,
  input  logic [NUM_REGS-1:0] entryValid,
  input  tag_t                entryTag [NUM_REGS],
  output strobes_t            strobes
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_comb begin
      strobes.alloc[i]  = issueValid && (issueDst == REG_W'(i));
      strobes.retire[i] = cdbValid && entryValid[i] && (entryTag[i] == cdbTag);
    end
  end

endmodule

// File: rtl/rrs_table.sv
module rrs_table
  import rrs_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strobes,
  input  tag_t                issueTag,
  input  regIdx_t             srcAIdx,
  input  regIdx_t             srcBIdx,
  output logic [NUM_REGS-1:0] entryValid,
  output tag_t                entryTag [NUM_REGS],
  output logic                srcAReady,
  output tag_t                srcATag,
  output logic                srcAFwd,
  output logic                srcBReady,
  output tag_t                srcBTag,
  output logic                srcBFwd
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryValid[i] <= 1'b0;
        entryTag[i]   <= '0;
      end else if (strobes.alloc[i]) begin
        entryValid[i] <= 1'b1;
        entryTag[i]   <= issueTag;
      end else if (strobes.retire[i]) begin
        entryValid[i] <= 1'b0;
      end
    end

    AST_ALLOC_RECORDS: assert property (@(posedge clk) disable iff (!rstN)
      strobes.alloc[i] |=> entryValid[i] && entryTag[i] == $past(issueTag)); // R2
    AST_ISSUE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      strobes.alloc[i] && strobes.retire[i] |=> entryValid[i]); // R6
    AST_RETIRE_BLANKS: assert property (@(posedge clk) disable iff (!rstN)
      strobes.retire[i] && !strobes.alloc[i] |=> !entryValid[i]); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.alloc[i] && !strobes.retire[i] |=> $stable(entryValid[i]) && $stable(entryTag[i])); // R5
  end

  always_comb begin
    srcAFwd   = strobes.retire[srcAIdx];
    srcAReady = !entryValid[srcAIdx] || srcAFwd;
    srcATag   = entryTag[srcAIdx];
    srcBFwd   = strobes.retire[srcBIdx];
    srcBReady = !entryValid[srcBIdx] || srcBFwd;
    srcBTag   = entryTag[srcBIdx];
  end

  AST_BLANK_READY: assert property (@(posedge clk) disable iff (!rstN)
    !entryValid[srcAIdx] |-> srcAReady && !srcAFwd); // R3

endmodule

// File: rtl/regstat_rename.sv
module regstat_rename
  import rrs_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  input  logic [REG_W-1:0]    issueDst,
  input  logic [TAG_W-1:0]    issueTag,
  input  logic [REG_W-1:0]    srcAIdx,
  input  logic [REG_W-1:0]    srcBIdx,
  input  logic                cdbValid,
  input  logic [TAG_W-1:0]    cdbTag,
  input  logic [DATA_W-1:0]   cdbData,
  output logic                srcAReady,
  output logic [TAG_W-1:0]    srcATag,
  output logic                srcAFwd,
  output logic [DATA_W-1:0]   srcAFwdData,
  output logic                srcBReady,
  output logic [TAG_W-1:0]    srcBTag,
  output logic                srcBFwd,
  output logic [DATA_W-1:0]   srcBFwdData,
  output logic [NUM_REGS-1:0] rfWrEn,
  output logic [DATA_W-1:0]   rfWrData
);

  strobes_t            strobes;
  logic [NUM_REGS-1:0] entryValid;
  tag_t                entryTag [NUM_REGS];

  rrs_ctrl u_ctrl (
    .issueValid (issueValid),
    .issueDst   (issueDst),
    .cdbValid   (cdbValid),
    .cdbTag     (cdbTag),
    .entryValid (entryValid),
    .entryTag   (entryTag),
    .strobes    (strobes)
  );

  rrs_table u_table (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .issueTag   (issueTag),
    .srcAIdx    (srcAIdx),
    .srcBIdx    (srcBIdx),
    .entryValid (entryValid),
    .entryTag   (entryTag),
    .srcAReady  (srcAReady),
    .srcATag    (srcATag),
    .srcAFwd    (srcAFwd),
    .srcBReady  (srcBReady),
    .srcBTag    (srcBTag),
    .srcBFwd    (srcBFwd)
  );

  assign srcAFwdData = srcAFwd ? cdbData : '0;
  assign srcBFwdData = srcBFwd ? cdbData : '0;
  assign rfWrEn      = strobes.retire;
  assign rfWrData    = cdbData;

  AST_FWD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    srcBFwd |-> srcBReady && srcBFwdData == cdbData); // R7
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cdbValid |-> rfWrEn == '0); // R10
  AST_RESET_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> srcAReady && srcBReady && !srcAFwd && !srcBFwd); // R1

endmodule

// File: tb/regstat_rename_tb.sv
module regstat_rename_tb;
  import rrs_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                issueValid = 1'b0;
  logic [REG_W-1:0]    issueDst = '0;
  logic [TAG_W-1:0]    issueTag = '0;
  logic [REG_W-1:0]    srcAIdx = '0;
  logic [REG_W-1:0]    srcBIdx = '0;
  logic                cdbValid = 1'b0;
  logic [TAG_W-1:0]    cdbTag = '0;
  logic [DATA_W-1:0]   cdbData = '0;
  logic                srcAReady, srcAFwd, srcBReady, srcBFwd;
  logic [TAG_W-1:0]    srcATag, srcBTag;
  logic [DATA_W-1:0]   srcAFwdData, srcBFwdData, rfWrData;
  logic [NUM_REGS-1:0] rfWrEn;

  always #(CLK_PERIOD/2) clk = ~clk;

  regstat_rename u_dut (.*);

  typedef struct {
    string               req;
    logic                aReady, aFwd, bReady, bFwd;
    logic [TAG_W-1:0]    aTag, bTag;
    logic [DATA_W-1:0]   aData, bData, wrData;
    logic [NUM_REGS-1:0] wrEn;
  } exp_t;

  exp_t expQ[$];
  event chkEv;
  int   checks = 0;
  int   errors = 0;

  // Reference model built from the requirements
  logic mValid [NUM_REGS];
  logic [TAG_W-1:0] mTag [NUM_REGS];

  task automatic checkVal(string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(chkEv);
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checkVal(e.req, "srcAReady", DATA_W'(srcAReady), DATA_W'(e.aReady));
        checkVal(e.req, "srcAFwd", DATA_W'(srcAFwd), DATA_W'(e.aFwd));
        checkVal(e.req, "srcAFwdData", srcAFwdData, e.aData);
        if (!e.aReady) checkVal(e.req, "srcATag", DATA_W'(srcATag), DATA_W'(e.aTag));
        checkVal(e.req, "srcBReady", DATA_W'(srcBReady), DATA_W'(e.bReady));
        checkVal(e.req, "srcBFwd", DATA_W'(srcBFwd), DATA_W'(e.bFwd));
        checkVal(e.req, "srcBFwdData", srcBFwdData, e.bData);
        if (!e.bReady) checkVal(e.req, "srcBTag", DATA_W'(srcBTag), DATA_W'(e.bTag));
        checkVal(e.req, "rfWrEn", DATA_W'(rfWrEn), DATA_W'(e.wrEn));
        if (e.wrEn != '0) checkVal(e.req, "rfWrData", rfWrData, e.wrData);
      end
    end
  end

  // Driver: called at a falling edge, returns at the next falling edge
  task automatic step(string req, bit iv, int dst, int itag, bit cv, int ctag,
                      int cdata, int a, int b);
    exp_t e;
    logic [NUM_REGS-1:0] match;
    issueValid = iv;
    issueDst   = REG_W'(dst);
    issueTag   = TAG_W'(itag);
    cdbValid   = cv;
    cdbTag     = TAG_W'(ctag);
    cdbData    = DATA_W'(cdata);
    srcAIdx    = REG_W'(a);
    srcBIdx    = REG_W'(b);
    #1;
    for (int i = 0; i < NUM_REGS; i++)
      match[i] = cv && mValid[i] && (mTag[i] == TAG_W'(ctag));
    e.req    = req;
    e.aFwd   = match[a];
    e.aReady = !mValid[a] || match[a];
    e.aTag   = mTag[a];
    e.aData  = match[a] ? DATA_W'(cdata) : '0;
    e.bFwd   = match[b];
    e.bReady = !mValid[b] || match[b];
    e.bTag   = mTag[b];
    e.bData  = match[b] ? DATA_W'(cdata) : '0;
    e.wrEn   = match;
    e.wrData = DATA_W'(cdata);
    expQ.push_back(e);
    ->chkEv;
    @(posedge clk);
    for (int i = 0; i < NUM_REGS; i++) begin
      if (iv && dst == i) begin
        mValid[i] = 1'b1;
        mTag[i]   = TAG_W'(itag);
      end else if (match[i]) begin
        mValid[i] = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NUM_REGS; i++) begin
      mValid[i] = 1'b0;
      mTag[i]   = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: blank after reset, broadcast writes nothing
    step("R1", 0, 0, 0, 0, 0, 0, 0, 7);
    step("R1", 0, 0, 0, 1, 3, 'h55, 1, 2);
    // R9: same-cycle lookup sees pre-issue state; R2 afterwards
    step("R9", 1, 2, 5, 0, 0, 0, 2, 3);
    step("R2", 0, 0, 0, 0, 0, 0, 2, 3);
    step("R2", 1, 4, 9, 0, 0, 0, 2, 4);
    step("R2", 1, 6, 1, 0, 0, 0, 4, 6);
    // R7 bypass + R4 write enable
    step("R7", 0, 0, 0, 1, 9, 'hCAFE, 4, 6);
    step("R4", 0, 0, 0, 0, 0, 0, 4, 6);
    // R5: rename r6 then broadcast the older tag
    step("R5", 1, 6, 12, 0, 0, 0, 6, 2);
    step("R5", 0, 0, 0, 1, 1, 'h1111, 6, 2);
    step("R5", 0, 0, 0, 0, 0, 0, 6, 3);
    // R6: issue to r2 while old producer 5 broadcasts
    step("R6", 1, 2, 7, 1, 5, 'h2222, 2, 6);
    step("R6", 0, 0, 0, 0, 0, 0, 2, 6);
    // R10: invalid strobes change nothing
    step("R10", 0, 6, 3, 0, 12, 'h3333, 6, 2);
    step("R10", 0, 0, 0, 0, 0, 0, 6, 2);
    // R8: clear only the matching register
    step("R8", 0, 0, 0, 1, 12, 'h4444, 6, 2);
    step("R8", 0, 0, 0, 0, 0, 0, 6, 2);
    // R3: blank lookups
    step("R3", 0, 0, 0, 0, 0, 0, 0, 5);
    // R8: fill every register, then retire in reverse order
    for (int i = 0; i < NUM_REGS; i++)
      step("R8", 1, i, (i + 8) % NUM_TAGS, 0, 0, 0, i, (i + 1) % NUM_REGS);
    for (int i = NUM_REGS - 1; i >= 0; i--)
      step("R8", 0, 0, 0, 1, (i + 8) % NUM_TAGS, 'h100 + i, i, (i + NUM_REGS - 1) % NUM_REGS);
    step("R3", 0, 0, 0, 0, 0, 0, 1, 6);
    finishRun();
  end

endmodule